// File: doc/BRIEF.md
# Crest/Valley Interrupt Thinner with Buffered Compare Reload

This block sits next to a triangular (up/down) PWM counter. It takes the counter's peak and bottom event strobes and lets only every (N+1)-th enabled event raise an interrupt, where N is a 5-bit skip count. One skip counter is shared by both sources, so when both are enabled, peak and bottom events advance the same count.

The block also holds a bank of compare registers. Each register has a staging copy that the write port loads and an active copy that the PWM stage reads. In deferred mode the staged values move into the active copies only at a transfer point. In thinned-transfer mode a transfer point is every event that raises an interrupt. In armed-transfer mode a transfer point is the first enabled event after compare register 1 has been written. In immediate mode a write goes straight into the active copy as well.

Top module: `irq_thinner`

## Requirements
- R1: After reset both interrupt outputs are 0, every active compare value is 0 and the skip count is 0.
- R2: With skip count N, the first N enabled events after a counter restart raise no interrupt and the next one raises one. The pattern then repeats with period N+1.
- R3: With skip count 0, every enabled event raises its interrupt.
- R4: An event whose source enable is 0 raises no interrupt and does not advance the skip counter.
- R5: When both sources are enabled, peak and bottom events count interchangeably in the same skip counter. The interrupt appears on the output of the source that caused the firing event.
- R6: Writing the skip count (skipWr=1 for one cycle) loads the new value and restarts the skip counter from zero.
- R7: With immMode=0 and xferCull=1, all staged compare values are copied into the active copies on the edge of an event that raises an interrupt. They become visible the cycle after it, and suppressed events copy nothing.
- R8: With immMode=0 and xferCull=0, writing compare register 1 arms a transfer. The next enabled event copies all staged values into the active copies and disarms the transfer. Enabled events that find the transfer unarmed copy nothing.
- R9: With immMode=1, a compare write appears on the addressed active copy in the cycle after the write, with no event needed.
- R10: Writing a compare register other than register 1 does not arm a transfer.
- R11: An interrupt output is high only during the cycle in which its causing event strobe is high. It is driven from that strobe with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| crestEvt | input | 1 | Counter peak event strobe |
| valleyEvt | input | 1 | Counter bottom event strobe |
| crestEn | input | 1 | Enables the peak interrupt and its counting |
| valleyEn | input | 1 | Enables the bottom interrupt and its counting |
| skipWr | input | 1 | Loads skipData into the skip count and restarts the counter |
| skipData | input | CNT_W | New skip count |
| xferCull | input | 1 | 1: transfer on interrupt-raising events; 0: armed transfer |
| immMode | input | 1 | 1: compare writes take effect immediately |
| cmpWr | input | 1 | Compare register write strobe |
| cmpSel | input | SEL_W | Compare register index |
| cmpData | input | DW | Compare write data |
| crestIrq | output | 1 | Thinned peak interrupt pulse |
| valleyIrq | output | 1 | Thinned bottom interrupt pulse |
| actCmp | output | NCMP*DW | Active compare values, register i at bits [i*DW +: DW] |

## Verification
Two cases are hard to reach from the ports. The first is telling a suppressed event apart from one that would have fired. The bench settles this by writing the skip count, then driving an exact number of events and comparing each pulse against a counted model. Restarting the counter mid-run, and feeding in events from a disabled source, show up as a pulse that arrives one event late or early. The second case is armed-transfer mode. There the bench first writes a compare register other than register 1 and drives an event to show that nothing moves. It then writes register 1 and drives an event that the skip count suppresses, which proves the transfer does not depend on the interrupt.

// File: rtl/irq_thin_pkg.sv
package irq_thin_pkg;
  typedef struct packed {
    logic doXfer;    // copy every staged value into its active copy
    logic wrStage;   // load staged copy at cmpSel
    logic wrActive;  // load active copy at cmpSel directly
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_thin_ctrl.sv
module irq_thin_ctrl
  import irq_thin_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int SEL_W   = 2,
  parameter int ARM_IDX = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             crestEvt,
  input  logic             valleyEvt,
  input  logic             crestEn,
  input  logic             valleyEn,
  input  logic             skipWr,
  input  logic [CNT_W-1:0] skipData,
  input  logic             xferCull,
  input  logic             immMode,
  input  logic             cmpWr,
  input  logic [SEL_W-1:0] cmpSel,
  output logic             crestIrq,
  output logic             valleyIrq,
  output ctrlStrobes_t     strobes
);
  logic [CNT_W-1:0] skipReg;
  logic [CNT_W-1:0] skipCnt;
  logic             pending;
  logic             crestHit;
  logic             valleyHit;
  logic             anyHit;
  logic             fire;
  logic             armWr;

  assign crestHit  = crestEvt & crestEn;
  assign valleyHit = valleyEvt & valleyEn;
  assign anyHit    = crestHit | valleyHit;
  assign fire      = anyHit & (skipCnt == skipReg);
  assign crestIrq  = fire & crestHit;
  assign valleyIrq = fire & valleyHit;
  assign armWr     = cmpWr & (cmpSel == SEL_W'(ARM_IDX));

  always_comb begin
    strobes.wrStage  = cmpWr;
    strobes.wrActive = cmpWr & immMode;
    strobes.doXfer   = ~immMode & (xferCull ? fire : (pending & anyHit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipReg <= '0;
      skipCnt <= '0;
    end else if (skipWr) begin
      skipReg <= skipData;
      skipCnt <= '0;
    end else if (fire) begin
      skipCnt <= '0;
    end else if (anyHit) begin
      skipCnt <= skipCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pending <= 1'b0;
    else if (armWr)          pending <= 1'b1;
    else if (strobes.doXfer) pending <= 1'b0;
  end
endmodule

// File: rtl/irq_thin_data.sv
module irq_thin_data
  import irq_thin_pkg::*;
#(
  parameter int NCMP  = 4,
  parameter int DW    = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [SEL_W-1:0] cmpSel,
  input  logic [DW-1:0]    cmpData,
  output logic [NCMP*DW-1:0] actCmp
);
  for (genvar i = 0; i < NCMP; i++) begin : g_reg
    logic [DW-1:0] staged;
    logic [DW-1:0] active;
    logic          hitSel;

    assign hitSel = (cmpSel == SEL_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           staged <= '0;
      else if (strobes.wrStage && hitSel)  staged <= cmpData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           active <= '0;
      else if (strobes.wrActive && hitSel) active <= cmpData;
      else if (strobes.doXfer)             active <= staged;
    end

    assign actCmp[i*DW +: DW] = active;
  end
endmodule

// File: rtl/irq_thinner.sv
module irq_thinner
  import irq_thin_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int NCMP  = 4,
  parameter int DW    = 16,
  localparam int SEL_W = (NCMP > 1) ? $clog2(NCMP) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               crestEvt,
  input  logic               valleyEvt,
  input  logic               crestEn,
  input  logic               valleyEn,
  input  logic               skipWr,
  input  logic [CNT_W-1:0]   skipData,
  input  logic               xferCull,
  input  logic               immMode,
  input  logic               cmpWr,
  input  logic [SEL_W-1:0]   cmpSel,
  input  logic [DW-1:0]      cmpData,
  output logic               crestIrq,
  output logic               valleyIrq,
  output logic [NCMP*DW-1:0] actCmp
);
  ctrlStrobes_t strobes;

  irq_thin_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ARM_IDX(1)) u_ctrl (
    .clk(clk), .rstN(rstN), .crestEvt(crestEvt), .valleyEvt(valleyEvt),
    .crestEn(crestEn), .valleyEn(valleyEn), .skipWr(skipWr), .skipData(skipData),
    .xferCull(xferCull), .immMode(immMode), .cmpWr(cmpWr), .cmpSel(cmpSel),
    .crestIrq(crestIrq), .valleyIrq(valleyIrq), .strobes(strobes)
  );

  irq_thin_data #(.NCMP(NCMP), .DW(DW), .SEL_W(SEL_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmpSel(cmpSel),
    .cmpData(cmpData), .actCmp(actCmp)
  );
endmodule

// File: rtl/irq_thinner_chk.sv
module irq_thinner_chk #(
  parameter int NCMP  = 4,
  parameter int DW    = 16,
  parameter int SEL_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               crestEvt,
  input logic               valleyEvt,
  input logic               crestEn,
  input logic               valleyEn,
  input logic               immMode,
  input logic               cmpWr,
  input logic [SEL_W-1:0]   cmpSel,
  input logic [DW-1:0]      cmpData,
  input logic               crestIrq,
  input logic               valleyIrq,
  input logic [NCMP*DW-1:0] actCmp
);
  // R11: a peak interrupt needs its enabled strobe in the same cycle
  p_crest_aligned_r11: assert property (@(posedge clk) disable iff (!rstN)
    crestIrq |-> (crestEvt && crestEn));

  // R11: a bottom interrupt needs its enabled strobe in the same cycle
  p_valley_aligned_r11: assert property (@(posedge clk) disable iff (!rstN)
    valleyIrq |-> (valleyEvt && valleyEn));

  // R4: a disabled source stays quiet
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!crestEn |-> !crestIrq) and (!valleyEn |-> !valleyIrq));

  // R7 and R8: with no enabled event and no write, active copies hold
  p_hold_no_point_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!(crestEvt && crestEn) && !(valleyEvt && valleyEn) && !cmpWr) |=> $stable(actCmp));

  // R9: an immediate write to register 0 shows up the next cycle
  p_imm_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmpWr && immMode && cmpSel == '0) |=> (actCmp[DW-1:0] == $past(cmpData)));
endmodule

bind irq_thinner irq_thinner_chk #(.NCMP(NCMP), .DW(DW), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .crestEvt(crestEvt), .valleyEvt(valleyEvt),
  .crestEn(crestEn), .valleyEn(valleyEn), .immMode(immMode), .cmpWr(cmpWr),
  .cmpSel(cmpSel), .cmpData(cmpData), .crestIrq(crestIrq), .valleyIrq(valleyIrq),
  .actCmp(actCmp)
);

// File: tb/irq_thinner_tb.sv
module irq_thinner_tb;
  localparam int CNT_W = 5;
  localparam int NCMP  = 4;
  localparam int DW    = 16;
  localparam int SEL_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic crestEvt = 0, valleyEvt = 0, crestEn = 0, valleyEn = 0;
  logic skipWr = 0;
  logic [CNT_W-1:0] skipData = '0;
  logic xferCull = 0, immMode = 0, cmpWr = 0;
  logic [SEL_W-1:0] cmpSel = '0;
  logic [DW-1:0] cmpData = '0;
  logic crestIrq, valleyIrq;
  logic [NCMP*DW-1:0] actCmp;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] expAct [NCMP];
  logic [DW-1:0] expStg [NCMP];

  always #2 clk = ~clk;

  irq_thinner #(.CNT_W(CNT_W), .NCMP(NCMP), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .crestEvt(crestEvt), .valleyEvt(valleyEvt),
    .crestEn(crestEn), .valleyEn(valleyEn), .skipWr(skipWr), .skipData(skipData),
    .xferCull(xferCull), .immMode(immMode), .cmpWr(cmpWr), .cmpSel(cmpSel),
    .cmpData(cmpData), .crestIrq(crestIrq), .valleyIrq(valleyIrq), .actCmp(actCmp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkAct(input string req);
    for (int i = 0; i < NCMP; i++)
      chk(actCmp[i*DW +: DW] == expAct[i], req, 32'(actCmp[i*DW +: DW]), 32'(expAct[i]));
  endtask

  task automatic evt(input bit c, input bit v, input bit ec, input bit ev, input string req);
    @(negedge clk); crestEvt = c; valleyEvt = v;
    #1;
    chk(crestIrq == ec, req, 32'(crestIrq), 32'(ec));
    chk(valleyIrq == ev, req, 32'(valleyIrq), 32'(ev));
    @(negedge clk); crestEvt = 0; valleyEvt = 0;
    #1;
    chk(!crestIrq && !valleyIrq, "R11 pulse width", 32'({crestIrq, valleyIrq}), 32'(0));
  endtask

  task automatic wrSkip(input int n);
    @(negedge clk); skipWr = 1; skipData = CNT_W'(n);
    @(negedge clk); skipWr = 0;
  endtask

  task automatic wrCmp(input int sel, input logic [DW-1:0] d);
    @(negedge clk); cmpWr = 1; cmpSel = SEL_W'(sel); cmpData = d;
    @(negedge clk); cmpWr = 0;
    expStg[sel] = d;
    if (immMode) expAct[sel] = d;
  endtask

  task automatic t_reset;
    #1;
    chk(!crestIrq && !valleyIrq, "R1 irq", 32'({crestIrq, valleyIrq}), 0);
    chk(actCmp == '0, "R1 actCmp", 32'(actCmp[31:0]), 0);
    crestEn = 1;
    evt(1, 0, 1, 0, "R1 skip count zero after reset");
  endtask

  task automatic t_skip0;
    crestEn = 1; valleyEn = 1; wrSkip(0);
    evt(1, 0, 1, 0, "R3 crest");
    evt(0, 1, 0, 1, "R3 valley");
    evt(1, 0, 1, 0, "R3 crest again");
  endtask

  task automatic t_cull;
    crestEn = 1; valleyEn = 0; wrSkip(2);
    for (int k = 0; k < 2; k++) begin
      evt(1, 0, 0, 0, "R2 skip1");
      evt(1, 0, 0, 0, "R2 skip2");
      evt(1, 0, 1, 0, "R2 fire");
    end
  endtask

  task automatic t_shared;
    crestEn = 1; valleyEn = 1; wrSkip(1);
    evt(1, 0, 0, 0, "R5 crest skipped");
    evt(0, 1, 0, 1, "R5 valley fires");
    evt(0, 1, 0, 0, "R5 valley skipped");
    evt(1, 0, 1, 0, "R5 crest fires");
  endtask

  task automatic t_disabled;
    crestEn = 1; valleyEn = 0; wrSkip(1);
    for (int k = 0; k < 3; k++) evt(0, 1, 0, 0, "R4 disabled valley");
    evt(1, 0, 0, 0, "R4 counter not advanced");
    evt(1, 0, 1, 0, "R4 crest fires");
  endtask

  task automatic t_skipwr;
    crestEn = 1; valleyEn = 0; wrSkip(2);
    evt(1, 0, 0, 0, "R6 pre1");
    evt(1, 0, 0, 0, "R6 pre2");
    wrSkip(2);
    evt(1, 0, 0, 0, "R6 restarted");
    evt(1, 0, 0, 0, "R6 second");
    evt(1, 0, 1, 0, "R6 fires");
  endtask

  task automatic t_cullxfer;
    crestEn = 1; valleyEn = 0; immMode = 0; xferCull = 1; wrSkip(1);
    wrCmp(0, 16'hA0A0);
    wrCmp(1, 16'hB1B1);
    chkAct("R7 no move on write");
    evt(1, 0, 0, 0, "R7 suppressed");
    chkAct("R7 no move on suppressed");
    evt(1, 0, 1, 0, "R7 firing");
    for (int i = 0; i < NCMP; i++) expAct[i] = expStg[i];
    chkAct("R7 moved on firing");
  endtask

  task automatic t_noncull;
    crestEn = 1; valleyEn = 0; immMode = 0; xferCull = 0; wrSkip(2);
    wrCmp(2, 16'hC2C2);
    evt(1, 0, 0, 0, "R10 event");
    chkAct("R10 no arm from reg 2");
    wrCmp(1, 16'hD1D1);
    evt(1, 0, 0, 0, "R8 event");
    for (int i = 0; i < NCMP; i++) expAct[i] = expStg[i];
    chkAct("R8 armed transfer");
    wrCmp(3, 16'hE3E3);
    evt(1, 0, 1, 0, "R8 event unarmed");
    chkAct("R8 disarmed");
  endtask

  task automatic t_imm;
    immMode = 1;
    wrCmp(3, 16'hF3F3);
    chkAct("R9 immediate reg 3");
    wrCmp(0, 16'h0F0F);
    chkAct("R9 immediate reg 0");
    immMode = 0;
  endtask

  initial begin
    for (int i = 0; i < NCMP; i++) begin expAct[i] = '0; expStg[i] = '0; end
    #1; t_reset_pre();
  end

  task automatic t_reset_pre;
    @(negedge clk); @(negedge clk); rstN = 1;
    t_reset();
    t_skip0();
    t_cull();
    t_shared();
    t_disabled();
    t_skipwr();
    t_cullxfer();
    t_noncull();
    t_imm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule